// File: doc/BRIEF.md
# Rotating-Window Loop Branch Controller

This block steers the closing branch of a modulo-scheduled loop. It keeps a 64-bit iteration counter and a 6-bit drain counter, plus two rotation offsets: one for the rotating general registers (numbers 32 to 127) and one for the rotating predicates (numbers 16 to 63). Each time a rotating loop branch executes, both offsets step down by one. A value written to virtual register r in one iteration is therefore read as virtual r+1 in the next. The same branch also writes the stage-enable predicate, which is virtual predicate 16 after the rotation: it writes 1 while iterations are still being started and 0 while the pipeline drains.

Software loads the two counters and clears the offsets before the loop starts. Two lookup ports translate virtual register numbers into physical ones for either register class. A second branch flavour counts iterations without rotating anything. Its outcome follows from the iteration counter alone.

Top module: `loop_rot_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both counters and both offsets are zero: lookups return their input unchanged and a rotating branch falls through.
- R2: Lookups never remap general registers below 32, predicates below 16, or predicate-class numbers of 64 and above. `lk_cls_*` = 0 selects general registers and 1 selects predicates.
- R3: Inside a rotating range, physical = LO + ((virtual − LO + k) mod N). LO/N are 32/96 for general registers and 16/48 for predicates. k is the class offset, kept in 0..N−1, and each rotation changes it to (k + N − 1) mod N.
- R4: A rotating branch (`br_kind` = 1) with a nonzero iteration count is taken. It decrements that count, rotates both offsets, and writes 1 to the stage predicate. `pw_num` is the physical number of virtual predicate 16 under the rotated offset.
- R5: A rotating branch with a zero iteration count and a nonzero drain count decrements the drain count, rotates both offsets and writes 0 to the stage predicate. It is taken only if the drain count was greater than one beforehand.
- R6: A rotating branch with both counts zero falls through, writes no predicate and changes no state.
- R7: A counting branch (`br_kind` = 0) is taken and decrements the iteration count while that count is nonzero, and falls through otherwise. It never rotates, never writes a predicate and leaves the drain count alone.
- R8: `clear_bases` sets both offsets to zero at the next edge and leaves both counters unchanged.
- R9: `lc_load` and `ec_load` load the counters at the next edge. If `clear_bases` or either load is high together with `br_valid`, the branch is ignored: not taken, no predicate write, no decrement, no rotation.
- R10: Starting from cleared offsets, an iteration count of 3 and a drain count of 2, five rotating branches give taken, taken, taken, taken, fall-through. Afterwards virtual general register 32 maps to 123 and virtual predicate 16 maps to 59 (both offsets at −5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_bases | input | 1 | Zero both rotation offsets |
| lc_load | input | 1 | Load the iteration counter |
| lc_value | input | 64 | Iteration count to load |
| ec_load | input | 1 | Load the drain counter |
| ec_value | input | 6 | Drain count to load |
| br_valid | input | 1 | A loop branch executes this cycle |
| br_kind | input | 1 | 1 = rotating branch, 0 = counting branch |
| lk_cls_a | input | 1 | Lookup A class (0 general, 1 predicate) |
| lk_vnum_a | input | 7 | Lookup A virtual number |
| lk_cls_b | input | 1 | Lookup B class |
| lk_vnum_b | input | 7 | Lookup B virtual number |
| br_taken | output | 1 | Branch decision for the current branch |
| pw_en | output | 1 | Stage-predicate write enable |
| pw_num | output | 6 | Physical predicate number written |
| pw_val | output | 1 | Value written to the stage predicate |
| lk_pnum_a | output | 7 | Lookup A physical number |
| lk_pnum_b | output | 7 | Lookup B physical number |

## Verification
The hardest state to reach is a fully drained loop: both counters at zero while rotating branches keep arriving. The other hard cases are an offset that wraps past zero after more than 48 or 96 rotations, and a branch that collides with a setup input. The random stimulus mostly loads small counts, so loops drain within a few branches and then keep branching on empty counters. Occasional large loads drive the offsets through full wraps. Directed sequences replay the 3/2 drain example, a long run of 120 iterations, and near-maximum 64-bit counts.

// File: rtl/loop_rot_pkg.sv
// Shared types for the rotating-window loop branch controller.
package loop_rot_pkg;
    typedef enum logic {
        BR_COUNT  = 1'b0,   // counting branch, no rotation
        BR_ROTATE = 1'b1    // rotating modulo-loop branch
    } br_kind_e;

    typedef enum logic {
        CLS_GR = 1'b0,
        CLS_PR = 1'b1
    } reg_cls_e;

    // Decision of one branch, consumed by counters and offset registers
    typedef struct packed {
        logic taken;
        logic dec_lc;
        logic dec_ec;
        logic rotate;
        logic pw_en;
        logic pw_val;
    } br_action_t;
endpackage

// File: rtl/loop_rot_base.sv
// Rotation offset register for one register class.
// Holds the offset as a value in 0..N-1, where N-1 stands for -1.
// Assumes clear and rotate are never meant to apply together (clear wins).
module loop_rot_base #(
    parameter int N  = 96,
    parameter int BW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rotate,
    output logic [BW-1:0] base_q,
    output logic [BW-1:0] base_next
);
    // offset after one downward rotation, wrapping at zero
    always_comb begin
        base_next = (base_q == '0) ? BW'(N - 1) : base_q - BW'(1);
    end

    // offset register: reset/clear to zero, else step on rotate
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (clear)  base_q <= '0;
        else if (rotate) base_q <= base_next;
    end
endmodule

// File: rtl/loop_rot_map.sv
// Virtual-to-physical register number translation for one class.
// Numbers in LO..LO+N-1 are shifted by the offset modulo N; others pass.
// Assumes the offset is below N and LO+N fits in VW+1 bits.
module loop_rot_map #(
    parameter int LO = 32,
    parameter int N  = 96,
    parameter int VW = 7,
    parameter int BW = 7
) (
    input  logic [VW-1:0] vnum,
    input  logic [BW-1:0] base,
    output logic [VW-1:0] pnum
);
    localparam int SW = VW + 1;
    localparam logic [SW-1:0] LO_S = SW'(LO);
    localparam logic [SW-1:0] HI_S = SW'(LO + N);
    localparam logic [SW-1:0] N_S  = SW'(N);

    logic [SW-1:0] v_s, off, sum, wrap;
    logic          in_rng;

    // range test, offset add and single conditional wrap
    always_comb begin
        v_s    = {1'b0, vnum};
        in_rng = (v_s >= LO_S) && (v_s < HI_S);
        off    = v_s - LO_S;
        sum    = off + SW'(base);
        wrap   = (sum >= N_S) ? sum - N_S : sum;
        pnum   = in_rng ? VW'(wrap + LO_S) : vnum;
    end
endmodule

// File: rtl/loop_count_ctl.sv
// Iteration and drain counters plus the branch decision logic.
// Assumes fire is already suppressed in cycles with a counter load.
module loop_count_ctl
    import loop_rot_pkg::*;
#(
    parameter int LC_W = 64,
    parameter int EC_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  br_kind_e        kind,
    input  logic            lc_load,
    input  logic [LC_W-1:0] lc_value,
    input  logic            ec_load,
    input  logic [EC_W-1:0] ec_value,
    output br_action_t      act,
    output logic [LC_W-1:0] lc_q,
    output logic [EC_W-1:0] ec_q
);
    logic lc_live, ec_live;

    // classify the counters and pick what the branch does
    always_comb begin
        lc_live = (lc_q != '0);
        ec_live = (ec_q != '0);
        act     = '0;
        if (fire) begin
            if (kind == BR_ROTATE) begin
                if (lc_live) begin
                    act.taken  = 1'b1;
                    act.dec_lc = 1'b1;
                    act.rotate = 1'b1;
                    act.pw_en  = 1'b1;
                    act.pw_val = 1'b1;
                end else if (ec_live) begin
                    act.taken  = (ec_q > EC_W'(1));
                    act.dec_ec = 1'b1;
                    act.rotate = 1'b1;
                    act.pw_en  = 1'b1;
                    act.pw_val = 1'b0;
                end
            end else if (lc_live) begin
                act.taken  = 1'b1;
                act.dec_lc = 1'b1;
            end
        end
    end

    // iteration counter: load, else decrement on a counted branch
    always_ff @(posedge clk) begin
        if (!rst_n)          lc_q <= '0;
        else if (lc_load)    lc_q <= lc_value;
        else if (act.dec_lc) lc_q <= lc_q - LC_W'(1);
    end

    // drain counter: load, else decrement during the drain phase
    always_ff @(posedge clk) begin
        if (!rst_n)          ec_q <= '0;
        else if (ec_load)    ec_q <= ec_value;
        else if (act.dec_ec) ec_q <= ec_q - EC_W'(1);
    end
endmodule

// File: rtl/loop_rot_ctrl.sv
// Top of the rotating-window loop branch controller.
// Combines the counters, one offset register per class, two lookup ports
// and the stage-predicate write. Setup inputs take priority over a branch.
module loop_rot_ctrl
    import loop_rot_pkg::*;
#(
    parameter int LC_W    = 64,
    parameter int EC_W    = 6,
    parameter int VW      = 7,
    parameter int GR_LO   = 32,
    parameter int GR_N    = 96,
    parameter int PR_LO   = 16,
    parameter int PR_N    = 48,
    parameter int N_PORTS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_bases,
    input  logic            lc_load,
    input  logic [LC_W-1:0] lc_value,
    input  logic            ec_load,
    input  logic [EC_W-1:0] ec_value,
    input  logic            br_valid,
    input  logic            br_kind,
    input  logic            lk_cls_a,
    input  logic [VW-1:0]   lk_vnum_a,
    input  logic            lk_cls_b,
    input  logic [VW-1:0]   lk_vnum_b,
    output logic            br_taken,
    output logic            pw_en,
    output logic [5:0]      pw_num,
    output logic            pw_val,
    output logic [VW-1:0]   lk_pnum_a,
    output logic [VW-1:0]   lk_pnum_b
);
    localparam int GR_BW = $clog2(GR_N);
    localparam int PR_BW = $clog2(PR_N);
    localparam int PW_VW = $clog2(PR_LO + PR_N);

    logic             fire;
    br_action_t       act;
    logic [LC_W-1:0]  lc_q;
    logic [EC_W-1:0]  ec_q;
    logic [GR_BW-1:0] gbase_q, gbase_next;
    logic [PR_BW-1:0] pbase_q, pbase_next;
    logic [PW_VW-1:0] pw_map;

    // a branch is honoured only when no setup input is active
    always_comb begin
        fire = br_valid && !(clear_bases || lc_load || ec_load);
    end

    loop_count_ctl #(.LC_W(LC_W), .EC_W(EC_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .kind     (br_kind_e'(br_kind)),
        .lc_load  (lc_load),
        .lc_value (lc_value),
        .ec_load  (ec_load),
        .ec_value (ec_value),
        .act      (act),
        .lc_q     (lc_q),
        .ec_q     (ec_q)
    );

    loop_rot_base #(.N(GR_N), .BW(GR_BW)) u_gbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_bases),
        .rotate    (act.rotate),
        .base_q    (gbase_q),
        .base_next (gbase_next)
    );

    loop_rot_base #(.N(PR_N), .BW(PR_BW)) u_pbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_bases),
        .rotate    (act.rotate),
        .base_q    (pbase_q),
        .base_next (pbase_next)
    );

    // stage predicate lands on virtual PR_LO under the rotated offset
    loop_rot_map #(.LO(PR_LO), .N(PR_N), .VW(PW_VW), .BW(PR_BW)) u_pwmap (
        .vnum (PW_VW'(PR_LO)),
        .base (pbase_next),
        .pnum (pw_map)
    );

    // branch outputs straight from the decision
    always_comb begin
        br_taken = act.taken;
        pw_en    = act.pw_en;
        pw_val   = act.pw_val;
        pw_num   = 6'(pw_map);
    end

    logic          lk_cls [N_PORTS];
    logic [VW-1:0] lk_vn  [N_PORTS];
    logic [VW-1:0] lk_pn  [N_PORTS];

    // gather the lookup ports into arrays
    always_comb begin
        lk_cls[0] = lk_cls_a;
        lk_vn[0]  = lk_vnum_a;
        lk_cls[1] = lk_cls_b;
        lk_vn[1]  = lk_vnum_b;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_PORTS; gi++) begin : g_lookup
            logic [VW-1:0] gr_p, pr_p;

            loop_rot_map #(.LO(GR_LO), .N(GR_N), .VW(VW), .BW(GR_BW)) u_gmap (
                .vnum (lk_vn[gi]),
                .base (gbase_q),
                .pnum (gr_p)
            );

            loop_rot_map #(.LO(PR_LO), .N(PR_N), .VW(VW), .BW(PR_BW)) u_pmap (
                .vnum (lk_vn[gi]),
                .base (pbase_q),
                .pnum (pr_p)
            );

            // select the class translation for this port
            always_comb begin
                lk_pn[gi] = (reg_cls_e'(lk_cls[gi]) == CLS_PR) ? pr_p : gr_p;
            end
        end
    endgenerate

    // drive the lookup outputs
    always_comb begin
        lk_pnum_a = lk_pn[0];
        lk_pnum_b = lk_pn[1];
    end
endmodule

// File: rtl/loop_rot_ctrl_chk.sv
// Assertion checker for loop_rot_ctrl, attached by bind below.
module loop_rot_ctrl_chk #(
    parameter int LC_W  = 64,
    parameter int EC_W  = 6,
    parameter int VW    = 7,
    parameter int GR_LO = 32,
    parameter int GR_N  = 96,
    parameter int GR_BW = 7,
    parameter int PR_BW = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_bases,
    input logic             lc_load,
    input logic             ec_load,
    input logic             br_valid,
    input logic             br_kind,
    input logic             br_taken,
    input logic             pw_en,
    input logic             pw_val,
    input logic [LC_W-1:0]  lc_q,
    input logic [EC_W-1:0]  ec_q,
    input logic [GR_BW-1:0] gbase_q,
    input logic [PR_BW-1:0] pbase_q,
    input logic             lk_cls_a,
    input logic [VW-1:0]    lk_vnum_a,
    input logic [VW-1:0]   lk_pnum_a
);
    logic fire_c;
    // branch accepted from the port view
    always_comb fire_c = br_valid && !clear_bases && !lc_load && !ec_load;

    // R4 / R7: a branch with live iteration count decrements it
    a_r4_lc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && lc_q != '0) |=> (lc_q == $past(lc_q) - LC_W'(1)));

    // R5: drain phase decrements the drain counter
    a_r5_ec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && br_kind && lc_q == '0 && ec_q != '0) |=> (ec_q == $past(ec_q) - EC_W'(1)));

    // R4 / R5: predicate value follows the phase
    a_r5_pw_phase: assert property (@(posedge clk) disable iff (!rst_n)
        pw_en |-> (pw_val == (lc_q != '0)));

    // R3: general offset steps down with wrap on a rotation
    a_r3_gbase_rot: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && br_kind && (lc_q != '0 || ec_q != '0)) |=>
        (gbase_q == (($past(gbase_q) == '0) ? GR_BW'(GR_N - 1) : $past(gbase_q) - GR_BW'(1))));

    // R6: drained loop falls through silently
    a_r6_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && br_kind && lc_q == '0 && ec_q == '0) |-> (!br_taken && !pw_en));

    // R7: counting branch leaves offsets and drain counter alone
    a_r7_no_rot: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && !br_kind) |=> ($stable(gbase_q) && $stable(pbase_q) && $stable(ec_q)));

    // R8: clear zeroes both offsets
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_bases |=> (gbase_q == '0 && pbase_q == '0));

    // R9: setup input suppresses the branch
    a_r9_setup_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_bases || lc_load || ec_load) |-> (!br_taken && !pw_en));

    // R2: low general registers are never remapped
    a_r2_low_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_cls_a && lk_vnum_a < VW'(GR_LO)) |-> (lk_pnum_a == lk_vnum_a));
endmodule

bind loop_rot_ctrl loop_rot_ctrl_chk #(
    .LC_W(LC_W), .EC_W(EC_W), .VW(VW), .GR_LO(GR_LO), .GR_N(GR_N),
    .GR_BW(GR_BW), .PR_BW(PR_BW)
) u_chk (.*);

// File: tb/loop_rot_ctrl_bench.sv
module loop_rot_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clear_bases, lc_load, ec_load, br_valid, br_kind;
    logic [63:0] lc_value;
    logic [5:0]  ec_value;
    logic        lk_cls_a, lk_cls_b;
    logic [6:0]  lk_vnum_a, lk_vnum_b;
    logic        br_taken, pw_en, pw_val;
    logic [5:0]  pw_num;
    logic [6:0]  lk_pnum_a, lk_pnum_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    logic [63:0] m_lc;
    int          m_ec, m_gb, m_pb;

    loop_rot_ctrl u_loop_rot_ctrl (
        .clk(clk), .rst_n(rst_n), .clear_bases(clear_bases),
        .lc_load(lc_load), .lc_value(lc_value), .ec_load(ec_load),
        .ec_value(ec_value), .br_valid(br_valid), .br_kind(br_kind),
        .lk_cls_a(lk_cls_a), .lk_vnum_a(lk_vnum_a),
        .lk_cls_b(lk_cls_b), .lk_vnum_b(lk_vnum_b),
        .br_taken(br_taken), .pw_en(pw_en), .pw_num(pw_num), .pw_val(pw_val),
        .lk_pnum_a(lk_pnum_a), .lk_pnum_b(lk_pnum_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_map(bit cls, int v, int gb, int pb);
        if (!cls) return (v >= 32 && v < 128) ? 32 + ((v - 32 + gb) % 96) : v;
        return (v >= 16 && v < 64) ? 16 + ((v - 16 + pb) % 48) : v;
    endfunction

    function automatic string map_req(bit cls, int v);
        if (!cls) return (v < 32) ? "R2" : "R3";
        return (v < 16 || v >= 64) ? "R2" : "R3";
    endfunction

    // one cycle: drive after negedge, check before posedge, advance model
    task automatic run_cycle(bit clr, bit lcl, logic [63:0] lcv, bit ecl, int ecv,
                             bit bv, bit kind);
        bit    fire, e_tk, e_pw, e_pv, rot;
        string rq;
        @(negedge clk);
        clear_bases = clr; lc_load = lcl; lc_value = lcv;
        ec_load = ecl; ec_value = 6'(ecv); br_valid = bv; br_kind = kind;
        lk_cls_a = 1'($urandom); lk_vnum_a = 7'($urandom);
        lk_cls_b = 1'($urandom); lk_vnum_b = 7'($urandom);
        #2;
        check(map_req(lk_cls_a, lk_vnum_a), lk_pnum_a, exp_map(lk_cls_a, lk_vnum_a, m_gb, m_pb));
        check(map_req(lk_cls_b, lk_vnum_b), lk_pnum_b, exp_map(lk_cls_b, lk_vnum_b, m_gb, m_pb));
        fire = bv && !clr && !lcl && !ecl;
        e_tk = 0; e_pw = 0; e_pv = 0; rot = 0;
        rq = (bv && !fire) ? "R9" : "R7";
        if (fire && kind) begin
            if (m_lc != 0) begin
                rq = "R4"; e_tk = 1; e_pw = 1; e_pv = 1; rot = 1; m_lc = m_lc - 1;
            end else if (m_ec != 0) begin
                rq = "R5"; e_tk = (m_ec > 1); e_pw = 1; rot = 1; m_ec = m_ec - 1;
            end else rq = "R6";
        end else if (fire && m_lc != 0) begin
            e_tk = 1; m_lc = m_lc - 1;
        end
        check(rq, br_taken, e_tk);
        check(rq, pw_en, e_pw);
        if (e_pw) begin
            check(rq, pw_val, e_pv);
            check(rq, pw_num, 16 + ((m_pb + 47) % 48));
        end
        if (rot) begin m_gb = (m_gb + 95) % 96; m_pb = (m_pb + 47) % 48; end
        if (clr) begin m_gb = 0; m_pb = 0; end
        if (lcl) m_lc = lcv;
        if (ecl) m_ec = ecv;
    endtask

    task automatic lookup_now(bit cls, int v, int exp, string req);
        @(negedge clk);
        clear_bases = 0; lc_load = 0; ec_load = 0; br_valid = 0;
        lk_cls_a = cls; lk_vnum_a = 7'(v);
        #2;
        check(req, lk_pnum_a, exp);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; clear_bases = 0; lc_load = 0; ec_load = 0; br_valid = 0; br_kind = 0;
        lc_value = '0; ec_value = '0; lk_cls_a = 0; lk_cls_b = 0; lk_vnum_a = '0; lk_vnum_b = '0;
        m_lc = 0; m_ec = 0; m_gb = 0; m_pb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state observed at ports
        #2;
        check("R1", br_taken, 0);
        check("R1", pw_en, 0);
        lookup_now(0, 100, 100, "R1");
        lookup_now(1, 40, 40, "R1");
        run_cycle(0, 0, 0, 0, 0, 1, 1);   // R1: drained rotating branch
        check("R1", br_taken, 0);

        // R10: directed drain example
        run_cycle(1, 0, 0, 0, 0, 0, 0);
        run_cycle(0, 1, 64'd3, 1, 2, 0, 0);
        for (int i = 0; i < 5; i++) begin
            run_cycle(0, 0, 0, 0, 0, 1, 1);
            check("R10", br_taken, (i < 4) ? 1 : 0);
        end
        lookup_now(0, 32, 123, "R10");
        lookup_now(1, 16, 59, "R10");
        // R6: further branch on drained loop changes nothing
        run_cycle(0, 0, 0, 0, 0, 1, 1);
        lookup_now(0, 32, 123, "R6");

        // R9: collision of setup with branch
        run_cycle(0, 1, 64'd5, 0, 0, 1, 1);
        run_cycle(0, 0, 0, 1, 3, 1, 0);
        run_cycle(1, 0, 0, 0, 0, 1, 1);
        // R8: clear keeps counters (5 iterations still pending)
        lookup_now(0, 32, 32, "R8");
        for (int i = 0; i < 5; i++) run_cycle(0, 0, 0, 0, 0, 1, 0);
        run_cycle(0, 0, 0, 0, 0, 1, 0);
        check("R8", br_taken, 0);

        // R3: long loop wrapping both offsets
        run_cycle(0, 1, 64'd120, 1, 1, 0, 0);
        for (int i = 0; i < 121; i++) run_cycle(0, 0, 0, 0, 0, 1, 1);
        lookup_now(0, 127, 32 + ((95 + m_gb) % 96), "R3");

        // R7: wide counts near the top of the 64-bit range
        run_cycle(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) run_cycle(0, 0, 0, 0, 0, 1, 0);
        run_cycle(0, 1, 64'h0000_0100_0000_0000, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) run_cycle(0, 0, 0, 0, 0, 1, 1);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 100);
            bit clr = (r < 4);
            bit lcl = (r >= 4 && r < 12);
            bit ecl = (r >= 10 && r < 18);
            logic [63:0] lcv = ($urandom % 16 == 0) ? 64'($urandom % 200) : 64'($urandom % 6);
            run_cycle(clr, lcl, lcv, ecl, int'($urandom % 5),
                      ($urandom % 10) < 7, 1'($urandom));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule